// File: doc/BRIEF.md
# Smart-Card Character Transmit Scheduler

This block sends single characters from a host to a smart card over the card's shared, open-drain style I/O line. It uses the asynchronous character framing of ISO 7816: a low start bit, eight data bits and an even-parity bit, each lasting one elementary time unit (ETU). The host always writes a byte in direct convention. When the card has selected inverse convention, the block converts the byte while building the frame. The block drives the line only while the ten frame bits are on the wire. At every other time the line is released, so the card can signal an error or answer.

Timing comes from a fractional tick input that pulses `TICKS_PER_ETU` times per ETU. The default is ten, which gives tenth-of-ETU resolution. Starts of successive characters are spaced by at least 12.5 ETU plus a programmable guard time. A write that arrives inside that window is held and launched exactly when the window closes. A write that arrives after the window has closed is launched on the next clock. In protocol T=0 the block samples the line at 10.5 ETU. A low level there means the card has rejected the character. The block then raises a parity-error flag together with the transmit-empty flag at 10.8 ETU. The host answers by writing the same byte again, and that retry may start as soon as 13 ETU after the failed start bit, whatever the guard time.

Top module: `scTxScheduler`

## Requirements
- R1: After reset the line is released (`ioDriveEn`=0, `ioDriveLvl`=1), `txEmpty` is 1 and `parityErr` is 0.
- R2: A frame is ten bit cells of one ETU each: a low start bit, eight data cells and a parity cell. The line is released from 10 ETU after the start bit onwards, and whenever no frame is on the wire.
- R3: With `inverseConv`=0, data cell k (k=1..8) carries `wrData[k-1]` uninverted, least significant bit first. The parity cell carries the XOR of the eight data bits.
- R4: With `inverseConv`=1, data cell k carries the inverse of `wrData[8-k]`, most significant bit first. The parity cell carries the inverse of the XOR of the eight data bits.
- R5: A write accepted when at least the spacing limit has passed since the previous start bit starts its start bit on the clock that samples the strobe. The spacing limit is 12.5 ETU plus `guardEtu` ETU. Before any character has been sent, the limit is treated as already passed.
- R6: A write accepted earlier than the spacing limit is held. Its start bit begins exactly at the spacing limit, counted in ticks from the previous start bit.
- R7: An accepted write clears `txEmpty` on the next clock. `txEmpty` returns to 1 exactly 10.8 ETU (108 ticks by default) after that character's start bit.
- R8: With `protoT0`=1, the released line is sampled at 10.5 ETU. A low level sets `parityErr` at the same time `txEmpty` is set. The next accepted write clears `parityErr`.
- R9: After a character flagged by R8, the spacing limit for the next character is 13 ETU, whatever `guardEtu` is.
- R10: With `protoT0`=0, a low line level during the error window sets no flag and does not change the spacing limit.
- R11: A write strobe while `txEmpty` is 0 is ignored. The held or in-flight character, and its timing, are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fracTick | input | 1 | Pulses TICKS_PER_ETU times per ETU |
| wrStb | input | 1 | Host write strobe, one clock |
| wrData | input | 8 | Character in direct convention |
| guardEtu | input | 8 | Extra guard time in whole ETUs |
| inverseConv | input | 1 | 1 = card uses inverse convention |
| protoT0 | input | 1 | 1 = protocol T=0 (error signalling active) |
| ioIn | input | 1 | Sampled level of the card I/O line |
| ioDriveEn | output | 1 | 1 = block drives the I/O line |
| ioDriveLvl | output | 1 | Level driven; 1 when released |
| txEmpty | output | 1 | Ready for a new character |
| parityErr | output | 1 | Card signalled an error on the last character |

## Verification
The assertions check on every cycle the behaviour that does not depend on the ETU count. The line is driven only while a character is outstanding. Every frame begins with a low cell. `txEmpty` rises only after the line has been released, and it falls only after a write strobe. `parityErr` rises only together with `txEmpty`, and only in T=0. The exact bit order and inversion of both conventions, the tick-exact placement of deferred and immediate starts, the 13 ETU retry spacing and the ignored busy writes can only be shown by the bench's scenarios. The bench measures those against a tick counter of its own and a card model that pulls the line low.

// File: rtl/scTxPkg.sv
package scTxPkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // take host byte into the holding register
    logic load;     // build the line frame and start the start bit
    logic shift;    // advance to the next bit cell
  } txStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SEND = 2'd2
  } txState_e;

endpackage

// File: rtl/scTxDatapath.sv
module scTxDatapath
  import scTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inverseConv,
  output logic              lineBit
);

  localparam int FRAME_BITS = DATA_W + 2;

  logic [DATA_W-1:0]     holdReg;
  logic [DATA_W-1:0]     srcByte;
  logic [FRAME_BITS-1:0] frameNext;
  logic [FRAME_BITS-1:0] frameReg;
  logic                  evenPar;

  // An immediate start uses the byte on the bus in the same cycle
  assign srcByte = stb.capture ? wrData : holdReg;
  assign evenPar = ^srcByte;

  // Line-level frame, cell 0 first on the wire
  assign frameNext[0] = 1'b0;
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
      assign frameNext[1+i] = inverseConv ? ~srcByte[DATA_W-1-i] : srcByte[i];
    end
  endgenerate
  assign frameNext[FRAME_BITS-1] = inverseConv ? ~evenPar : evenPar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      frameReg <= '1;
    end else begin
      if (stb.capture) holdReg <= wrData;
      if (stb.load) begin
        frameReg <= frameNext;
      end else if (stb.shift) begin
        frameReg <= {1'b1, frameReg[FRAME_BITS-1:1]};
      end
    end
  end

  assign lineBit = frameReg[0];

endmodule

// File: rtl/scTxControl.sv
module scTxControl
  import scTxPkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_ETU = 10,
  parameter int GUARD_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fracTick,
  input  logic               wrStb,
  input  logic [GUARD_W-1:0] guardEtu,
  input  logic               protoT0,
  input  logic               ioIn,
  output txStrobes_t         stb,
  output logic               driveEn,
  output logic               txEmpty,
  output logic               parityErr
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int FRAME_END  = FRAME_BITS * TICKS_PER_ETU;
  localparam int SAMPLE_AT  = FRAME_END + TICKS_PER_ETU / 2;
  localparam int DONE_AT    = FRAME_END + (8 * TICKS_PER_ETU) / 10;
  localparam int SPACE_AT   = FRAME_END + (5 * TICKS_PER_ETU) / 2;
  localparam int RETRY_AT   = FRAME_END + 3 * TICKS_PER_ETU;
  localparam int MAX_LIMIT  = SPACE_AT + TICKS_PER_ETU * ((1 << GUARD_W) - 1);
  localparam int CNT_W      = $clog2(MAX_LIMIT + 1) + 1;
  localparam int SUB_W      = (TICKS_PER_ETU > 1) ? $clog2(TICKS_PER_ETU) : 1;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);

  txState_e         state;
  logic [CNT_W-1:0] elapsed;
  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             errSeen;
  logic             retryPend;

  logic [CNT_W-1:0] limit;
  logic             accept;
  logic             ready;
  logic             startNow;
  logic             sending;
  logic             cellEnd;
  logic             sampleNow;
  logic             doneNow;

  // Spacing limit from the previous start bit
  always_comb begin
    if (retryPend) begin
      limit = CNT_W'(RETRY_AT);
    end else begin
      limit = CNT_W'(SPACE_AT) + CNT_W'(guardEtu) * CNT_W'(TICKS_PER_ETU);
    end
  end

  assign sending   = (state == ST_SEND);
  assign accept    = wrStb && txEmpty;
  assign ready     = (elapsed >= limit);
  assign startNow  = ((state == ST_IDLE) && accept && ready) ||
                     ((state == ST_PEND) && ready);
  assign cellEnd   = sending && fracTick && (subCnt == SUB_W'(TICKS_PER_ETU - 1));
  assign sampleNow = sending && fracTick && (elapsed == CNT_W'(SAMPLE_AT - 1));
  assign doneNow   = sending && fracTick && (elapsed == CNT_W'(DONE_AT - 1));
  assign driveEn   = sending && (bitIdx < BIT_W'(FRAME_BITS));

  assign stb.capture = accept;
  assign stb.load    = startNow;
  assign stb.shift   = cellEnd && (bitIdx < BIT_W'(FRAME_BITS));

  // Ticks since the last start bit, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '1;
    end else if (startNow) begin
      elapsed <= '0;
    end else if (fracTick && (elapsed != '1)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // Position inside the frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt <= '0;
      bitIdx <= '0;
    end else if (startNow) begin
      subCnt <= '0;
      bitIdx <= '0;
    end else begin
      if (cellEnd) begin
        subCnt <= '0;
      end else if (sending && fracTick) begin
        subCnt <= subCnt + 1'b1;
      end
      if (stb.shift) bitIdx <= bitIdx + 1'b1;
    end
  end

  // Sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ready ? ST_SEND : ST_PEND;
        ST_PEND: if (ready) state <= ST_SEND;
        ST_SEND: if (doneNow) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Card error window and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSeen   <= 1'b0;
      retryPend <= 1'b0;
      txEmpty   <= 1'b1;
      parityErr <= 1'b0;
    end else begin
      if (startNow) begin
        errSeen <= 1'b0;
      end else if (sampleNow && protoT0 && !ioIn) begin
        errSeen <= 1'b1;
      end

      if (startNow) begin
        retryPend <= 1'b0;
      end else if (doneNow) begin
        retryPend <= errSeen;
      end

      if (accept) begin
        txEmpty   <= 1'b0;
        parityErr <= 1'b0;
      end else if (doneNow) begin
        txEmpty   <= 1'b1;
        parityErr <= errSeen;
      end
    end
  end

endmodule

// File: rtl/scTxScheduler.sv
module scTxScheduler
  import scTxPkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_ETU = 10,
  parameter int GUARD_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fracTick,
  input  logic               wrStb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [GUARD_W-1:0] guardEtu,
  input  logic               inverseConv,
  input  logic               protoT0,
  input  logic               ioIn,
  output logic               ioDriveEn,
  output logic               ioDriveLvl,
  output logic               txEmpty,
  output logic               parityErr
);

  txStrobes_t stb;
  logic       driveEn;
  logic       lineBit;

  scTxControl #(
    .DATA_W       (DATA_W),
    .TICKS_PER_ETU(TICKS_PER_ETU),
    .GUARD_W      (GUARD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fracTick (fracTick),
    .wrStb    (wrStb),
    .guardEtu (guardEtu),
    .protoT0  (protoT0),
    .ioIn     (ioIn),
    .stb      (stb),
    .driveEn  (driveEn),
    .txEmpty  (txEmpty),
    .parityErr(parityErr)
  );

  scTxDatapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .inverseConv(inverseConv),
    .lineBit    (lineBit)
  );

  assign ioDriveEn  = driveEn;
  assign ioDriveLvl = driveEn ? lineBit : 1'b1;

endmodule

// File: rtl/scTxChecker.sv
module scTxChecker (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic protoT0,
  input logic ioDriveEn,
  input logic ioDriveLvl,
  input logic txEmpty,
  input logic parityErr
);

  // R2: the line is driven only while a character is outstanding
  p_drive_only_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ioDriveEn |-> !txEmpty);

  // R2: every frame opens with a low start cell
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioDriveEn) |-> !ioDriveLvl);

  // R7: the empty flag returns only after the line has been released
  p_empty_after_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> !ioDriveEn);

  // R7: the empty flag falls only after a host write
  p_empty_falls_on_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(wrStb));

  // R8 and R10: the error flag rises with the empty flag, and only in T=0
  p_err_with_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> (txEmpty && protoT0));

endmodule

bind scTxScheduler scTxChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrStb     (wrStb),
  .protoT0   (protoT0),
  .ioDriveEn (ioDriveEn),
  .ioDriveLvl(ioDriveLvl),
  .txEmpty   (txEmpty),
  .parityErr (parityErr)
);

// File: tb/scTxScheduler_tb.sv
`timescale 1ns/1ps
module scTxScheduler_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fracTick = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] guardEtu = 8'd0;
  logic       inverseConv = 1'b0;
  logic       protoT0 = 1'b0;
  logic       ioIn;
  logic       ioDriveEn;
  logic       ioDriveLvl;
  logic       txEmpty;
  logic       parityErr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tickNo = 0;
  logic cardPull = 1'b0;
  logic finished = 1'b0;

  // Expectations handed from the stimulus to the monitor
  logic [7:0] expData = 8'h00;
  logic       expInv = 1'b0;
  logic       expInject = 1'b0;
  logic       expErr = 1'b0;
  int         expGap = 0;
  string      gapTag = "R5";

  always #5 clk = ~clk;

  // Card model: open line reads high unless the card pulls it low
  assign ioIn = ioDriveEn ? ioDriveLvl : !cardPull;

  scTxScheduler u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .fracTick   (fracTick),
    .wrStb      (wrStb),
    .wrData     (wrData),
    .guardEtu   (guardEtu),
    .inverseConv(inverseConv),
    .protoT0    (protoT0),
    .ioIn       (ioIn),
    .ioDriveEn  (ioDriveEn),
    .ioDriveLvl (ioDriveLvl),
    .txEmpty    (txEmpty),
    .parityErr  (parityErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fracTick) tickNo <= tickNo + 1;
  end

  // One tick every four clocks, on posedges whose count is a multiple of four
  always @(negedge clk) fracTick <= ((cyc + 1) % 4 == 0);

  function automatic logic expBit(input logic [7:0] d, input logic inv, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return inv ? ~(^d) : (^d);
    return inv ? ~d[8-k] : d[k-1];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Frame monitor, works in ticks since the observed start bit
  int   lastStart = -1000000;
  int   lastRel = -1;
  logic prevEn = 1'b0;
  logic inFrame = 1'b0;
  logic haveStart = 1'b0;
  logic [7:0] curData = 8'h00;
  logic curInv = 1'b0;
  logic curInject = 1'b0;
  logic curErr = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ioDriveEn && !prevEn) begin
        if (haveStart)
          check((tickNo - lastStart) == expGap, gapTag, tickNo - lastStart, expGap);
        lastStart = tickNo;
        haveStart = 1'b1;
        inFrame   = 1'b1;
        lastRel   = -1;
        curData   = expData;
        curInv    = expInv;
        curInject = expInject;
        curErr    = expErr;
      end
      prevEn = ioDriveEn;
      if (inFrame) begin
        int rel;
        rel = tickNo - lastStart;
        if (rel != lastRel) begin
          lastRel = rel;
          if (rel < 100 && rel % 10 == 5) begin
            int k;
            k = rel / 10;
            check(ioDriveEn && (ioDriveLvl == expBit(curData, curInv, k)),
                  curInv ? "R4 cell" : "R3 cell", int'(ioDriveLvl),
                  int'(expBit(curData, curInv, k)));
          end
          if (rel == 102) check(!ioDriveEn && ioDriveLvl, "R2 release", int'(ioDriveEn), 0);
          if (rel == 107) check(!txEmpty, "R7 empty early", int'(txEmpty), 0);
          if (rel == 108) begin
            check(txEmpty, "R7 empty at 10.8", int'(txEmpty), 1);
            check(parityErr == curErr, curErr ? "R8 error flag" : "R10 no flag",
                  int'(parityErr), int'(curErr));
            inFrame = 1'b0;
          end
          cardPull = curInject && rel >= 101 && rel <= 107;
        end
      end else begin
        cardPull = 1'b0;
      end
    end
  end

  task automatic alignWrite();
    do @(negedge clk); while ((cyc + 1) % 4 != 2);
  endtask

  // Send one character; returns whether the card flagged it
  task automatic sendChar(input logic [7:0] d, input logic inv, input logic t0,
                          input logic inject, input logic [7:0] g,
                          input logic prevErr, input int delayTicks,
                          input logic busyWrite);
    int limit;
    int writeRel;
    limit = prevErr ? 130 : 125 + 10 * int'(g);
    repeat (delayTicks * 4) @(negedge clk);
    alignWrite();
    inverseConv = inv;
    protoT0     = t0;
    guardEtu    = g;
    expData     = d;
    expInv      = inv;
    expInject   = inject;
    expErr      = t0 && inject;
    writeRel    = tickNo - lastStart;
    expGap      = (writeRel >= limit) ? writeRel : limit;
    gapTag      = (writeRel >= limit) ? "R5 immediate" : (prevErr ? "R9 retry" : "R6 deferred");
    wrData      = d;
    wrStb       = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    check(!txEmpty, "R7 clear on write", int'(txEmpty), 0);
    check(!parityErr, "R8 clear on write", int'(parityErr), 0);
    if (writeRel >= limit)
      check(ioDriveEn && !ioDriveLvl, "R5 start next clock", int'(ioDriveEn), 1);
    if (busyWrite) begin
      repeat (3) @(negedge clk);
      wrData = ~d;
      wrStb  = 1'b1;
      @(negedge clk);
      wrStb  = 1'b0;
      check(!txEmpty, "R11 busy write", int'(txEmpty), 0);
    end
    do @(negedge clk); while (!txEmpty);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1357));
    repeat (4) @(negedge clk);
    check(!ioDriveEn && ioDriveLvl, "R1 line", int'(ioDriveEn), 0);
    check(txEmpty, "R1 empty", int'(txEmpty), 1);
    check(!parityErr, "R1 error", int'(parityErr), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!ioDriveEn && txEmpty, "R1 after release", int'(ioDriveEn), 0);

    // Directed corners
    sendChar(8'h3B, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 0, 1'b0);  // R3, R5 first char
    sendChar(8'h3F, 1'b1, 1'b0, 1'b0, 8'd2, 1'b0, 0, 1'b1);  // R4, R6, R11
    sendChar(8'hA5, 1'b0, 1'b1, 1'b1, 8'd3, 1'b0, 0, 1'b0);  // R8
    sendChar(8'hA5, 1'b0, 1'b1, 1'b0, 8'd3, 1'b1, 0, 1'b0);  // R9 retry at 13 ETU
    sendChar(8'h00, 1'b1, 1'b0, 1'b1, 8'd1, 1'b0, 0, 1'b0);  // R10 pull ignored
    sendChar(8'hFF, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 40, 1'b0); // R5 late write

    // Random mix
    begin
      logic [7:0] d;
      logic       prevErr;
      d = 8'h00;
      prevErr = 1'b0;
      for (int n = 0; n < 20; n++) begin
        logic inv, t0, inj, busy;
        logic [7:0] g;
        int dl;
        inv  = 1'($urandom % 2);
        t0   = prevErr ? 1'b1 : 1'($urandom % 2);
        inj  = ($urandom % 3) == 0;
        busy = 1'($urandom % 2);
        g    = 8'($urandom % 4);
        dl   = int'($urandom % 50);
        if (!prevErr) d = 8'($urandom);
        sendChar(d, inv, t0, inj, g, prevErr, dl, busy);
        prevErr = t0 && inj;
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule